// File: doc/BRIEF.md
# Pin Control Register with Edge/Level Event Detector

This block holds the configuration of one I/O pin in a single 32-bit word and watches that pin for events. Software writes the word to select a pull direction, enable the pull, pick one of eight pin functions and choose an event mode. A two-stage synchroniser brings the asynchronous pin into the clock domain. A detector then looks for a rising edge, a falling edge, either edge, a low level or a high level, as the event mode selects. A detected event sets a sticky status bit. That bit drives either the interrupt line or the DMA request line, depending on the mode family.

In the DMA family the status bit clears by itself when the transfer-complete strobe arrives. In the interrupt family software must clear it by writing one to it. A lock bit can freeze the lower sixteen bits of the word until the next reset. The event mode and the status bit stay writable while locked. Register access is a plain single-cycle write port with a combinational read. The pad, the pull resistors and the function multiplexer themselves lie outside the block: it only drives their select signals.

Top module: `pin_event_ctrl`

## Requirements
- R1: After reset every field is zero: `rd_data` reads 0x0000_0000 and `irq`, `dma_req`, `pull_up`, `pull_dn` and `mux_sel` are all 0.
- R2: The word decodes as follows:
  - bit 0 is pull direction (1 = up);
  - bit 1 is pull enable;
  - bits 10:8 are the function select, which appears on `mux_sel`;
  - bit 15 is lock;
  - bits 19:16 are the event mode;
  - bit 24 is the status bit.

  All other bits read as 0.
- R3: Event modes 0001, 0010 and 0011 set the status bit on a rising edge, a falling edge and either edge respectively. In these modes `dma_req` follows the status bit and `irq` stays 0.
- R4: Event modes 1001, 1010 and 1011 set the status bit on a rising edge, a falling edge and either edge respectively. In these modes `irq` follows the status bit and `dma_req` stays 0.
- R5: Event mode 1000 sets the status bit while the pin is 0, and event mode 1100 sets it while the pin is 1. Both drive `irq`.
- R6: In a level mode, if the pin is still at the active level when the status bit is cleared, the status bit reads 1 again in the following cycle.
- R7: Event mode 0000 and the reserved modes 0100–0111 and 1101–1111 never set the status bit, `irq` or `dma_req`.
- R8: Writing 1 to bit 24 clears the status bit. Writing 0 to bit 24 leaves it unchanged. If a detection occurs in the same cycle as a clear, the status bit stays set.
- R9: A one-cycle pulse on `dma_done` clears the status bit in modes 0001–0011. It has no effect in the interrupt modes.
- R10: Once bit 15 is 1, writes leave bits 15:0 unchanged until reset, while bits 19:16 and bit 24 still respond to writes.
- R11: `pull_up` = pull enable & direction & (function select != 000). `pull_dn` = pull enable & !direction & (function select != 000).
- R12: A pin edge is visible on `irq`/`dma_req` after exactly three rising clock edges: it is absent after two and present after three.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Current register value |
| pin_in | input | 1 | Asynchronous pin level |
| dma_done | input | 1 | Transfer-complete strobe |
| pull_up | output | 1 | Pull-up select to pad |
| pull_dn | output | 1 | Pull-down select to pad |
| mux_sel | output | 3 | Function select to pin multiplexer |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench targets the status bit's corner cases:
- A clear that coincides with an active level: a design that let the clear win would show the level-low interrupt dropping for one cycle.
- `dma_done` arriving in an interrupt mode: a design that ignored the mode family would lose an interrupt.
- Reserved event codes: they are swept with pin toggles, so a decoder that treated, for example, 1101 like 1001 or 1100 would raise a flag.
- Writes after lock: a bad mask would either alter the pull and function fields or wrongly freeze the event mode.
- Synchroniser latency: it is pinned to three edges, which exposes a missing or extra stage.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;
  localparam int WORD_W  = 32;
  localparam int FSEL_W  = 3;
  localparam int MODE_W  = 4;
  localparam int B_DIR   = 0;
  localparam int B_PEN   = 1;
  localparam int B_FSEL  = 8;
  localparam int B_LOCK  = 15;
  localparam int B_MODE  = 16;
  localparam int B_STAT  = 24;

  typedef struct packed {
    logic to_dma;
    logic to_irq;
    logic on_rise;
    logic on_fall;
    logic on_low;
    logic on_high;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] m);
    mode_dec_t d;
    d = '0;
    case (m)
      4'b0001: begin d.to_dma = 1'b1; d.on_rise = 1'b1; end
      4'b0010: begin d.to_dma = 1'b1; d.on_fall = 1'b1; end
      4'b0011: begin d.to_dma = 1'b1; d.on_rise = 1'b1; d.on_fall = 1'b1; end
      4'b1000: begin d.to_irq = 1'b1; d.on_low  = 1'b1; end
      4'b1001: begin d.to_irq = 1'b1; d.on_rise = 1'b1; end
      4'b1010: begin d.to_irq = 1'b1; d.on_fall = 1'b1; end
      4'b1011: begin d.to_irq = 1'b1; d.on_rise = 1'b1; d.on_fall = 1'b1; end
      4'b1100: begin d.to_irq = 1'b1; d.on_high = 1'b1; end
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pin_cfg_reg.sv
module pin_cfg_reg
  import pin_event_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_dir,
  input  logic              wr_pen,
  input  logic [FSEL_W-1:0] wr_fsel,
  input  logic              wr_lock,
  input  logic [MODE_W-1:0] wr_mode,
  output logic              dir_q,
  output logic              pen_q,
  output logic [FSEL_W-1:0] fsel_q,
  output logic              lock_q,
  output logic [MODE_W-1:0] mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      pen_q  <= 1'b0;
      fsel_q <= '0;
      lock_q <= 1'b0;
    end else if (wr_en && !lock_q) begin
      dir_q  <= wr_dir;
      pen_q  <= wr_pen;
      fsel_q <= wr_fsel;
      lock_q <= wr_lock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= '0;
    else if (wr_en) mode_q <= wr_mode;
  end

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable({dir_q, pen_q, fsel_q}) && lock_q)) else $error("lock"); // R10
endmodule

// File: rtl/pin_detect.sv
module pin_detect
  import pin_event_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_s,
  input  logic [MODE_W-1:0] mode,
  input  logic              sw_clear,
  input  logic              dma_done,
  output logic              stat_q,
  output logic              irq,
  output logic              dma_req
);
  mode_dec_t dec;
  logic      prev_q;
  logic      rise, fall, hit, clr;

  assign dec  = decode_mode(mode);
  assign rise = pin_s & ~prev_q;
  assign fall = ~pin_s & prev_q;
  assign hit  = (dec.on_rise & rise) | (dec.on_fall & fall) |
                (dec.on_low & ~pin_s) | (dec.on_high & pin_s);
  assign clr  = sw_clear | (dma_done & dec.to_dma);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (hit)      stat_q <= 1'b1;
      else if (clr) stat_q <= 1'b0;
    end
  end

  assign irq     = stat_q & dec.to_irq;
  assign dma_req = stat_q & dec.to_dma;

  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q && !dec.to_irq && !dec.to_dma) |=> !stat_q) else $error("rsvd"); // R7
  AST_LEVEL_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    ((dec.on_low && !pin_s) || (dec.on_high && pin_s)) |=> stat_q) else $error("lvl"); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clear && !hit) |=> !stat_q) else $error("w1c"); // R8
  AST_DMA_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_done && dec.to_dma && !hit) |=> !stat_q) else $error("dma"); // R9
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && dma_req)) else $error("excl"); // R3
endmodule

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
  import pin_event_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              pin_in,
  input  logic              dma_done,
  output logic              pull_up,
  output logic              pull_dn,
  output logic [FSEL_W-1:0] mux_sel,
  output logic              irq,
  output logic              dma_req
);
  logic              dir_q, pen_q, lock_q, stat_q, pin_s, sw_clear, digital;
  logic [FSEL_W-1:0] fsel_q;
  logic [MODE_W-1:0] mode_q;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[WORD_W-1:B_STAT+1], wr_data[B_STAT-1:B_MODE+MODE_W],
                            wr_data[B_LOCK-1:B_FSEL+FSEL_W], wr_data[B_FSEL-1:B_PEN+1]};

  pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pin_s)
  );

  pin_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_dir(wr_data[B_DIR]), .wr_pen(wr_data[B_PEN]),
    .wr_fsel(wr_data[B_FSEL +: FSEL_W]), .wr_lock(wr_data[B_LOCK]),
    .wr_mode(wr_data[B_MODE +: MODE_W]),
    .dir_q(dir_q), .pen_q(pen_q), .fsel_q(fsel_q), .lock_q(lock_q), .mode_q(mode_q)
  );

  assign sw_clear = wr_en & wr_data[B_STAT];

  pin_detect u_det (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .mode(mode_q),
    .sw_clear(sw_clear), .dma_done(dma_done),
    .stat_q(stat_q), .irq(irq), .dma_req(dma_req)
  );

  always_comb begin
    rd_data = '0;
    rd_data[B_DIR]              = dir_q;
    rd_data[B_PEN]              = pen_q;
    rd_data[B_FSEL +: FSEL_W]   = fsel_q;
    rd_data[B_LOCK]             = lock_q;
    rd_data[B_MODE +: MODE_W]   = mode_q;
    rd_data[B_STAT]             = stat_q;
  end

  assign digital = (fsel_q != '0);
  assign pull_up = pen_q & dir_q & digital;
  assign pull_dn = pen_q & ~dir_q & digital;
  assign mux_sel = fsel_q;

  AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pull_up && pull_dn)) else $error("pull"); // R11
endmodule

// File: tb/pin_event_ctrl_bench.sv
module pin_event_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pin_in = 1'b0;
  logic        dma_done = 1'b0;
  logic        pull_up, pull_dn, irq, dma_req;
  logic [2:0]  mux_sel;
  int          errors = 0;
  int          checks = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  pin_event_ctrl u_pin_event_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pin_in(pin_in), .dma_done(dma_done), .pull_up(pull_up), .pull_dn(pull_dn),
    .mux_sel(mux_sel), .irq(irq), .dma_req(dma_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pin_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rd", rd_data, 32'h0);
    chk("R1 outs", {27'd0, irq, dma_req, pull_up, pull_dn, |mux_sel}, 32'h0);
  endtask

  task automatic t_fields();
    wr(32'hFFFF_7FFF & ~32'h0100_0000);
    chk("R2 readback", rd_data, 32'h000F_0703 & ~32'h0008_0000 | 32'h0008_0000);
    chk("R2 mux_sel", {29'd0, mux_sel}, 32'h7);
    wr(32'h0000_0000);
  endtask

  task automatic t_sync_latency();
    wr(32'h0009_0000);
    @(negedge clk); pin_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 two edges", {31'd0, irq}, 32'h0);
    @(negedge clk);
    chk("R12 three edges", {31'd0, irq}, 32'h1);
    wr(32'h0109_0000);
    chk("R8 w1c", {31'd0, irq}, 32'h0);
    set_pin(1'b0);
  endtask

  task automatic t_dma_edges();
    wr(32'h0001_0000);
    set_pin(1'b1);
    chk("R3 rise dma", {30'd0, irq, dma_req}, 32'h1);
    @(negedge clk); dma_done = 1'b1; @(negedge clk); dma_done = 1'b0;
    chk("R9 dma clear", rd_data, 32'h0001_0000);
    wr(32'h0002_0000);
    set_pin(1'b0);
    chk("R3 fall dma", {31'd0, dma_req}, 32'h1);
    @(negedge clk); dma_done = 1'b1; @(negedge clk); dma_done = 1'b0;
    wr(32'h0003_0000);
    set_pin(1'b1);
    chk("R3 either rise", {31'd0, dma_req}, 32'h1);
    @(negedge clk); dma_done = 1'b1; @(negedge clk); dma_done = 1'b0;
    set_pin(1'b0);
    chk("R3 either fall", {31'd0, dma_req}, 32'h1);
    @(negedge clk); dma_done = 1'b1; @(negedge clk); dma_done = 1'b0;
  endtask

  task automatic t_irq_edges();
    wr(32'h000A_0000);
    set_pin(1'b1);
    chk("R4 fall mode ignores rise", {31'd0, irq}, 32'h0);
    set_pin(1'b0);
    chk("R4 fall irq", {30'd0, irq, dma_req}, 32'h2);
    @(negedge clk); dma_done = 1'b1; @(negedge clk); dma_done = 1'b0;
    chk("R9 done ignored in irq mode", {31'd0, irq}, 32'h1);
    wr(32'h000A_0000);
    chk("R8 write0 no effect", rd_data, 32'h010A_0000);
    wr(32'h010B_0000);
    set_pin(1'b1);
    chk("R4 either rise", {31'd0, irq}, 32'h1);
    wr(32'h010B_0000);
    set_pin(1'b0);
    chk("R4 either fall", {31'd0, irq}, 32'h1);
    wr(32'h0109_0000);
    chk("R4 cleared", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_levels();
    wr(32'h0008_0000);
    @(negedge clk);
    chk("R5 low level", {31'd0, irq}, 32'h1);
    wr(32'h0108_0000);
    chk("R6 rearm after clear", {31'd0, irq}, 32'h1);
    set_pin(1'b1);
    wr(32'h0108_0000);
    chk("R6 clears once inactive", {31'd0, irq}, 32'h0);
    wr(32'h000C_0000);
    @(negedge clk);
    chk("R5 high level", {31'd0, irq}, 32'h1);
    set_pin(1'b0);
    wr(32'h0100_0000);
    chk("R8 clear", rd_data, 32'h0);
  endtask

  task automatic t_reserved();
    logic [3:0] codes [8] = '{4'h0, 4'h4, 4'h5, 4'h6, 4'h7, 4'hD, 4'hE, 4'hF};
    for (int i = 0; i < 8; i++) begin
      wr({12'd0, codes[i], 16'd0});
      set_pin(1'b1);
      chk("R7 reserved after rise", {30'd0, irq, dma_req, rd_data[24]} >> 0, 32'h0);
      set_pin(1'b0);
      chk("R7 reserved after fall", {30'd0, irq, dma_req, rd_data[24]} >> 0, 32'h0);
    end
  endtask

  task automatic t_pulls();
    wr(32'h0000_0003);
    chk("R11 analog no pull", {30'd0, pull_up, pull_dn}, 32'h0);
    wr(32'h0000_0103);
    chk("R11 pull up", {30'd0, pull_up, pull_dn}, 32'h2);
    wr(32'h0000_0102);
    chk("R11 pull down", {30'd0, pull_up, pull_dn}, 32'h1);
    wr(32'h0000_0101);
    chk("R11 pull disabled", {30'd0, pull_up, pull_dn}, 32'h0);
  endtask

  task automatic t_lock();
    wr(32'h0000_8103);
    wr(32'h0009_0000);
    chk("R10 low frozen, mode writable", rd_data, 32'h0009_8103);
    set_pin(1'b1);
    chk("R10 irq works locked", {31'd0, irq}, 32'h1);
    wr(32'h0109_0000);
    chk("R10 status writable", rd_data, 32'h0009_8103);
    do_reset();
    chk("R10 reset unlocks", rd_data, 32'h0);
  endtask

  initial begin
    t_reset();
    t_fields();
    t_sync_latency();
    t_dma_edges();
    t_irq_edges();
    t_levels();
    t_reserved();
    t_pulls();
    t_lock();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule